// File: doc/BRIEF.md
# Two-Dimensional Transfer Address Sequencer

This block generates the byte addresses for a rectangular memory transfer. A transfer is a grid of rows. Each row holds a fixed number of elements. Inside a row the address moves by an element stride. When a row ends, a separate row stride is added instead, so a single signed addition closes the row and jumps over the gap to the start of the next row. The block offers one address per beat on a valid/ready handshake. When the final element has been accepted, it either raises a completion flag or, in loop mode, reloads its configuration and starts again.

A typical use is to copy a small picture into the middle of a frame buffer. Take a buffer 480 pixels wide with 3 bytes per pixel, moved as 16-bit elements. A rectangle W pixels wide then uses an element count of W·3/2 and an element stride of 2. The row stride is (480−W)·3+2. The first address is the buffer base plus (x rounded down to even)·3 plus y·480·3. The data path, memory arbitration and error reporting belong to other blocks.

The configuration inputs are captured only on a rising edge of the enable. Once captured, they can change freely without disturbing the transfer in progress.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `addr_valid`, `busy` and `done` are low. A low-to-high change of `en` while idle captures every `cfg_*` input and clears `done`. One cycle later `addr_valid` is high with `addr_out` equal to the captured start address.
- R2: After an accepted beat that is not the last of its row, the next address is the previous one plus the sign-extended element stride.
- R3: After an accepted beat that is the last of its row, the next address is the previous one plus the sign-extended row stride, and the row restarts with the full element count. `row_end` is high exactly while the offered element is the last of its row.
- R4: A transfer offers element count × row count beats. After the last one is accepted with loop mode off, `busy` and `addr_valid` fall and `done` rises on the next cycle. `done` then stays high until the next start, and it is never high together with `busy`.
- R5: The address advances only on a cycle where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, `addr_out` holds.
- R6: With `cfg_auto` = 1, acceptance of the final beat reloads the start address and both counts. The pattern repeats, `busy` stays high and `done` stays low.
- R7: Changes on any `cfg_*` input while a transfer runs have no effect on the address sequence, `row_end` or `addr_wide`.
- R8: `addr_wide` reports the captured element size: 1 for 32-bit elements, 0 for 16-bit elements.
- R9: Strides are signed 16-bit byte offsets. Negative values step downward, and addresses wrap modulo 2^32.
- R10: Lowering `en` during a transfer aborts it. On the next cycle `busy` and `addr_valid` are low and `done` stays low.
- R11: A start with a zero element count or a zero row count offers no beats and sets `done` on the next cycle.
- R12: With the centring settings above, the first element of row r sits at base + ((y+r)·480 + even(x))·3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; rising edge starts, low aborts |
| cfg_start | input | 32 | Start byte address |
| cfg_xcount | input | 16 | Elements per row |
| cfg_xstride | input | 16 | Signed byte step between elements |
| cfg_ycount | input | 16 | Number of rows |
| cfg_ystride | input | 16 | Signed byte step after a row's last element |
| cfg_auto | input | 1 | Loop mode: restart after the final element |
| cfg_wide | input | 1 | Element size, 1 = 32-bit, 0 = 16-bit |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr_out | output | 32 | Offered byte address |
| addr_wide | output | 1 | Captured element size |
| row_end | output | 1 | Offered element is the last of its row |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |

## Verification
Random grids are run with small counts and mixed positive and negative strides, under a consumer that stalls at random. These separate errors in the element step from errors in the row step, and they expose an address that slips forward during a stall. Single-column and single-row shapes isolate the case where every element ends a row. A centred rectangle confirms the frame-buffer arithmetic against a closed-form row address. A run that scrambles every configuration input mid-transfer separates captured settings from live ones. Loop-mode runs over two frames check the reload. Mid-run aborts and zero-count starts check the edges of the control flow.

// File: rtl/d2_pkg.sv
package d2_pkg;
  localparam int ADDR_W   = 32;
  localparam int CNT_W    = 16;
  localparam int STRIDE_W = 16;
  localparam int EXT_W    = ADDR_W - STRIDE_W;

  typedef logic [ADDR_W-1:0]          addr_t;
  typedef logic [CNT_W-1:0]           cnt_t;
  typedef logic signed [STRIDE_W-1:0] stride_t;

  typedef struct packed {
    addr_t   start;
    cnt_t    xcount;
    stride_t xstride;
    cnt_t    ycount;
    stride_t ystride;
    logic    autobuf;
    logic    wide;
  } cfg_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;

  // sign-extend a byte stride to address width and add, wrapping modulo 2^ADDR_W
  function automatic addr_t step_addr(input addr_t a, input stride_t s);
    addr_t ext;
    ext = {{EXT_W{s[STRIDE_W-1]}}, s};
    return a + ext;
  endfunction

  // a grid with no rows or no columns has nothing to move
  function automatic logic grid_empty(input cfg_t c);
    return (c.xcount == '0) || (c.ycount == '0);
  endfunction

  function automatic logic is_last(input cnt_t n);
    return n == cnt_t'(1);
  endfunction
endpackage

// File: rtl/d2_cfg_latch.sv
module d2_cfg_latch
  import d2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  cfg_t cfg_d,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (capture) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/d2_row_ctr.sv
module d2_row_ctr
  import d2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fire,
  input  logic active,
  input  cnt_t xload,
  input  cnt_t yload,
  input  cnt_t xlimit,
  output cnt_t xcnt,
  output cnt_t ycnt,
  output logic last_in_row,
  output logic last_beat
);
  assign last_in_row = is_last(xcnt);
  assign last_beat   = last_in_row && is_last(ycnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt <= '0;
      ycnt <= '0;
    end else if (load) begin
      xcnt <= xload;
      ycnt <= yload;
    end else if (fire) begin
      if (last_in_row) begin
        xcnt <= xlimit;
        if (!last_beat) ycnt <= ycnt - cnt_t'(1);
      end else begin
        xcnt <= xcnt - cnt_t'(1);
      end
    end
  end

  // R3
  xcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (xcnt != '0) && (xcnt <= xlimit));
endmodule

// File: rtl/d2_addr_acc.sv
module d2_addr_acc
  import d2_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    fire,
  input  logic    last_in_row,
  input  logic    wrap,
  input  addr_t   start,
  input  stride_t xstride,
  input  stride_t ystride,
  output addr_t   addr
);
  addr_t next_addr;

  always_comb begin
    if (wrap)             next_addr = start;
    else if (last_in_row) next_addr = step_addr(addr, ystride);
    else                  next_addr = step_addr(addr, xstride);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= start;
    else if (fire)  addr <= next_addr;
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import d2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [31:0]       cfg_start,
  input  logic [15:0]       cfg_xcount,
  input  logic [15:0]       cfg_xstride,
  input  logic [15:0]       cfg_ycount,
  input  logic [15:0]       cfg_ystride,
  input  logic              cfg_auto,
  input  logic              cfg_wide,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [31:0]       addr_out,
  output logic              addr_wide,
  output logic              row_end,
  output logic              busy,
  output logic              done
);
  cfg_t   cfg_in, cfg_q;
  state_e state;
  logic   en_q, rise, start_go, start_empty;
  logic   fire, last_in_row, last_beat, wrap_now, ctr_load, finish;
  cnt_t   xcnt, ycnt, xload_mux, yload_mux;
  addr_t  start_mux;

  assign cfg_in = '{start: cfg_start, xcount: cfg_xcount, xstride: stride_t'(cfg_xstride),
                    ycount: cfg_ycount, ystride: stride_t'(cfg_ystride),
                    autobuf: cfg_auto, wide: cfg_wide};

  assign rise        = en && !en_q;
  assign start_go    = rise && (state == ST_IDLE) && !grid_empty(cfg_in);
  assign start_empty = rise && (state == ST_IDLE) && grid_empty(cfg_in);
  assign fire        = addr_valid && addr_ready;
  assign wrap_now    = fire && last_beat && cfg_q.autobuf;
  assign finish      = fire && last_beat && !cfg_q.autobuf;
  assign ctr_load    = start_go || wrap_now;

  // a fresh start takes the live inputs; a loop reload takes the captured copy
  assign xload_mux = start_go ? cfg_in.xcount : cfg_q.xcount;
  assign yload_mux = start_go ? cfg_in.ycount : cfg_q.ycount;
  assign start_mux = start_go ? cfg_in.start  : cfg_q.start;

  d2_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(start_go), .cfg_d(cfg_in), .cfg_q(cfg_q)
  );

  d2_row_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .fire(fire), .active(busy),
    .xload(xload_mux), .yload(yload_mux), .xlimit(cfg_q.xcount),
    .xcnt(xcnt), .ycnt(ycnt), .last_in_row(last_in_row), .last_beat(last_beat)
  );

  d2_addr_acc u_acc (
    .clk(clk), .rst_n(rst_n), .load(start_go), .fire(fire),
    .last_in_row(last_in_row), .wrap(wrap_now), .start(start_mux),
    .xstride(cfg_q.xstride), .ystride(cfg_q.ystride), .addr(addr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      en_q <= en;
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_go)         state <= ST_RUN;
            if (rise)             done  <= start_empty;
          end
          ST_RUN: begin
            if (finish) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy       = (state == ST_RUN);
  assign addr_valid = busy;
  assign addr_wide  = cfg_q.wide;
  assign row_end    = busy && last_in_row;

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> $stable(addr_out));
  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && finish |=> done && !busy);
  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R6
  auto_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && wrap_now |=> busy && !done && (addr_out == cfg_q.start));
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !en |=> !busy && !done);
  // R11
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_empty |=> done && !addr_valid);
endmodule

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [31:0] cfg_start = '0;
  logic [15:0] cfg_xcount = '0, cfg_xstride = '0, cfg_ycount = '0, cfg_ystride = '0;
  logic cfg_auto = 1'b0, cfg_wide = 1'b0, addr_ready = 1'b0;
  logic addr_valid, addr_wide, row_end, busy, done;
  logic [31:0] addr_out;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dma2d_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_start(cfg_start), .cfg_xcount(cfg_xcount),
    .cfg_xstride(cfg_xstride), .cfg_ycount(cfg_ycount), .cfg_ystride(cfg_ystride),
    .cfg_auto(cfg_auto), .cfg_wide(cfg_wide), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .addr_out(addr_out), .addr_wide(addr_wide),
    .row_end(row_end), .busy(busy), .done(done)
  );

  function automatic logic [31:0] sx(input logic [15:0] s);
    return {{16{s[15]}}, s};
  endfunction

  function automatic logic [31:0] centre_row(input logic [31:0] base, input int x, input int y, input int r);
    return base + 32'((((y + r) * 480) + (x & ~1)) * 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // centring parameters used by the R12 case
  logic [31:0] c_base = 32'h0001_0000;
  int c_x = 7, c_y = 3;

  task automatic run_case(input logic [31:0] st, input int xc, input logic [15:0] xs,
                          input int yc, input logic [15:0] ys, input bit autob, input bit wide,
                          input bit scramble, input bit centre, input string otag, input int stop_at);
    logic [31:0] exp;
    int c = 0, r = 0, beats = 0, frame = 0, total;
    bit rdy;
    string tg;
    total = xc * yc;
    @(negedge clk);
    cfg_start = st; cfg_xcount = 16'(xc); cfg_xstride = xs; cfg_ycount = 16'(yc);
    cfg_ystride = ys; cfg_auto = autob; cfg_wide = wide; addr_ready = 1'b0; en = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 || total == 0, "R1", {31'd0, done}, 32'd0);
    if (total == 0) begin
      chk(done === 1'b1 && addr_valid === 1'b0, "R11", {30'd0, done, addr_valid}, 32'd2);
      en = 1'b0;
      @(negedge clk);
      return;
    end
    exp = st;
    while (beats < stop_at) begin
      tg = (beats == 0) ? "R1" : (frame > 0) ? "R6" : (c == 0) ? "R3" : "R2";
      if (otag != "") tg = otag;
      chk(addr_valid === 1'b1 && busy === 1'b1, "R5", {30'd0, addr_valid, busy}, 32'd3);
      chk(addr_out === exp, tg, addr_out, exp);
      chk(row_end === (c == xc - 1), "R3", {31'd0, row_end}, {31'd0, c == xc - 1});
      chk(addr_wide === wide, "R8", {31'd0, addr_wide}, {31'd0, wide});
      if (centre && c == 0)
        chk(addr_out === centre_row(c_base, c_x, c_y, r), "R12", addr_out, centre_row(c_base, c_x, c_y, r));
      if (scramble) begin
        cfg_start = $urandom; cfg_xcount = 16'($urandom); cfg_xstride = 16'($urandom);
        cfg_ycount = 16'($urandom); cfg_ystride = 16'($urandom);
        cfg_auto = 1'($urandom); cfg_wide = 1'($urandom);
      end
      rdy = ($urandom % 4) != 0;
      addr_ready = rdy;
      if (rdy) begin
        beats++;
        if (c < xc - 1) begin
          exp = exp + sx(xs); c++;
        end else begin
          c = 0;
          if (r < yc - 1) begin
            exp = exp + sx(ys); r++;
          end else begin
            r = 0; frame++; exp = st;
          end
        end
      end
      @(negedge clk);
    end
    addr_ready = 1'b0;
    if (!autob && stop_at == total) begin
      chk(done === 1'b1 && busy === 1'b0 && addr_valid === 1'b0, "R4",
          {29'd0, done, busy, addr_valid}, 32'd4);
      repeat (3) @(negedge clk);
      chk(done === 1'b1 && addr_valid === 1'b0, "R4", {30'd0, done, addr_valid}, 32'd2);
      en = 1'b0;
      @(negedge clk);
      chk(done === 1'b1, "R4", {31'd0, done}, 32'd1);
    end else begin
      if (autob) begin
        chk(busy === 1'b1 && done === 1'b0, "R6", {30'd0, busy, done}, 32'd2);
        chk(addr_out === exp, "R6", addr_out, exp);
      end
      en = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0 && addr_valid === 1'b0 && done === 1'b0, "R10",
          {29'd0, busy, addr_valid, done}, 32'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(addr_valid === 1'b0 && busy === 1'b0 && done === 1'b0, "R1",
        {29'd0, addr_valid, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed shapes
    run_case(32'h0000_1000, 4, 16'd4, 3, 16'd100, 1'b0, 1'b1, 1'b0, 1'b0, "", 12);
    run_case(32'h0000_2000, 1, 16'd2, 5, 16'd64, 1'b0, 1'b0, 1'b0, 1'b0, "", 5);
    run_case(32'h0000_3000, 6, 16'd2, 1, 16'd8, 1'b0, 1'b0, 1'b0, 1'b0, "", 6);
    // R9: negative strides walking below zero
    run_case(32'h0000_0010, 3, 16'hFFFC, 3, 16'hFFE0, 1'b0, 1'b1, 1'b0, 1'b0, "R9", 9);
    // R12: centred 10x4 picture in a 480-wide 24-bit buffer
    run_case(c_base + 32'(((c_x & ~1) * 3) + (c_y * 480 * 3)), 15, 16'd2, 4,
             16'((480 - 10) * 3 + 2), 1'b0, 1'b0, 1'b0, 1'b1, "", 60);
    // R7: live inputs scrambled every beat
    run_case(32'h0000_4000, 3, 16'd4, 4, 16'd40, 1'b0, 1'b1, 1'b1, 1'b0, "R7", 12);
    // R6: loop mode over two full frames, then abort
    run_case(32'h0000_5000, 3, 16'd2, 2, 16'hFFF0, 1'b1, 1'b0, 1'b0, 1'b0, "", 12);
    // R10: abort partway
    run_case(32'h0000_6000, 4, 16'd4, 4, 16'd4, 1'b0, 1'b0, 1'b0, 1'b0, "", 7);
    // R11: empty grids
    run_case(32'h0000_7000, 0, 16'd2, 3, 16'd2, 1'b0, 1'b0, 1'b0, 1'b0, "", 0);
    run_case(32'h0000_7000, 3, 16'd2, 0, 16'd2, 1'b0, 1'b0, 1'b0, 1'b0, "", 0);
    // random grids
    for (int k = 0; k < 10; k++) begin
      int xc, yc;
      logic [15:0] xs, ys;
      xc = 1 + int'($urandom % 6);
      yc = 1 + int'($urandom % 5);
      xs = ($urandom % 2) ? 16'd2 : 16'hFFFE;
      ys = 16'(int'($urandom % 601) - 300);
      run_case($urandom, xc, xs, yc, ys, 1'b0, 1'($urandom), 1'b0, 1'b0, "", xc * yc);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule